// File: doc/BRIEF.md
# Supercolumn Nibble Serializer with Double-Rate Output

This block is the readout back end of a pixel array. It reads the counters one row at a time. Each read delivers one 4-bit nibble from every column at once. The columns are split into groups of `SCW` adjacent columns, called supercolumns. Each supercolumn turns its `4*SCW` bits into a serial stream on its own output line. The stream carries two bits per clock period: one bit is tagged for the rising edge and one for the falling edge. Every line runs in lockstep, so the whole row leaves the block in `2*SCW` cycles.

A frame starts with a `start` pulse. The counter depth is chosen on `depth` and captured when the frame starts. A deeper counter needs more nibble passes per row, and the block runs every pass of a row before it moves to the next row. The block asks its data source for each row and nibble through `req`, `req_row` and `req_nib`. The source must answer on `row_data` in that same cycle. The request comes during the last shift cycle of the previous pass, so the stream has no idle cycles between passes. When the final bit has left the block, `busy` falls and `done` pulses for one cycle.

The parameters `ROWS`, `COLS` and `SCW` set the array size, so a small array can be used for test.

Top module: `sc_ddr_serializer`

## Requirements
- R1: After reset, `busy`, `done`, `req` and `out_vld` are 0, and all `out_r` and `out_f` lines are 0.
- R2: A `start` seen while idle raises `busy` on the next edge. The cycle after that carries `req` with `req_row`=0 and `req_nib`=0, and `out_vld` is still 0. `out_vld` rises on the following cycle. `req` is high only in that first cycle and in the last shift cycle of a pass that has another pass after it. `row_data` is captured in every cycle where `req` is high.
- R3: Supercolumn s carries columns s*SCW to s*SCW+SCW-1, and its pixel nibble for column c sits at `row_data[4c+3:4c]`. The columns go out in ascending order, and each nibble goes out from its bit 3 down to its bit 0. In each cycle the earlier bit of the pair is on `out_r[s]` and the later bit is on `out_f[s]`.
- R4: All `COLS/SCW` lines shift in the same cycles, and each line carries its own columns.
- R5: Each row gets nibble passes 0 up to the last pass before the next row starts. Rows are read in ascending order.
- R6: `depth` is captured at `start`: 0 means 1 pass per row, 1 means 2 passes, and 2 or 3 mean 3 passes. A frame has exactly ROWS*passes*2*SCW valid cycles. Changing `depth` during a frame has no effect.
- R7: `out_vld` stays high without a break from the first valid cycle to the last one.
- R8: `busy` stays high through the last valid cycle. In the cycle right after it, `done` is 1, `busy` is 0 and `out_vld` is 0, and `done` is high for exactly that one cycle.
- R9: A `start` pulse while `busy` is high is ignored, and the frame keeps its length and order.
- R10: While `out_vld` is 0, every `out_r` and `out_f` line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (taken only when idle) |
| depth | input | 2 | Counter depth select: 0 gives 4 bits, 1 gives 8 bits, 2 or 3 give 12 bits |
| row_data | input | COLS*4 | Nibbles for the requested row and nibble, column c at bits 4c+3:4c |
| req | output | 1 | Row load request; row_data is captured in this cycle |
| req_row | output | clog2(ROWS) | Row being requested |
| req_nib | output | 2 | Nibble index being requested (0 is least significant) |
| out_r | output | COLS/SCW | Rising-edge bit, one per supercolumn |
| out_f | output | COLS/SCW | Falling-edge bit, one per supercolumn |
| out_vld | output | 1 | Output pair is valid |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest cases to reach are a `start` that arrives in the middle of a frame and a change of `depth` after a frame has begun. Both are harmless only if the captured depth and the pass pointer are left alone. The bench reaches these cases by pulsing `start` a few cycles into some frames and by changing `depth` right after every start. It then checks that the full bit stream, the number of valid cycles and the request sequence still match the depth given at start. Sweeping all four depth codes with different data seeds covers the step from one row to the next at every pass count.

// File: rtl/sc_ddr_serializer.sv
module sc_ddr_serializer #(
  parameter int ROWS = 256,
  parameter int COLS = 256,
  parameter int SCW  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [1:0]                  depth,
  input  logic [COLS*4-1:0]           row_data,
  output logic                        req,
  output logic [$clog2(ROWS)-1:0]     req_row,
  output logic [1:0]                  req_nib,
  output logic [COLS/SCW-1:0]         out_r,
  output logic [COLS/SCW-1:0]         out_f,
  output logic                        out_vld,
  output logic                        busy,
  output logic                        done
);
  localparam int NSC  = COLS / SCW;
  localparam int BITS = SCW * 4;
  localparam int CYC  = BITS / 2;
  localparam int RW   = $clog2(ROWS);
  localparam int PW   = (CYC > 1) ? $clog2(CYC) : 1;

  logic              busy_q, first_q, vld_q, last_q, done_q;
  logic [PW-1:0]     ph_q;
  logic [RW-1:0]     row_q;
  logic [1:0]        nib_q, np_q;
  logic [COLS*4-1:0] sreg_q, ld, sh;

  wire end_ph   = (ph_q == PW'(CYC - 1));
  wire ptr_last = (row_q == RW'(ROWS - 1)) && (nib_q == np_q);
  wire finish   = vld_q & end_ph & last_q;

  assign req     = first_q | (vld_q & end_ph & ~last_q);
  assign req_row = row_q;
  assign req_nib = nib_q;
  assign out_vld = vld_q;
  assign busy    = busy_q;
  assign done    = done_q;

  for (genvar s = 0; s < NSC; s++) begin : g_sc
    for (genvar k = 0; k < SCW; k++) begin : g_col
      assign ld[s*BITS + BITS - 1 - 4*k -: 4] = row_data[(s*SCW + k)*4 +: 4];
    end
    assign sh[s*BITS +: BITS] = {sreg_q[s*BITS +: BITS-2], 2'b00};
    assign out_r[s] = vld_q & sreg_q[s*BITS + BITS - 1];
    assign out_f[s] = vld_q & sreg_q[s*BITS + BITS - 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      vld_q   <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      ph_q    <= '0;
      row_q   <= '0;
      nib_q   <= '0;
      np_q    <= '0;
      sreg_q  <= '0;
    end else begin
      done_q <= finish;
      if (!busy_q && start) begin
        busy_q  <= 1'b1;
        first_q <= 1'b1;
        row_q   <= '0;
        nib_q   <= '0;
        last_q  <= 1'b0;
        np_q    <= (depth == 2'd0) ? 2'd0 : (depth == 2'd1) ? 2'd1 : 2'd2;
      end
      if (req) begin
        sreg_q  <= ld;
        vld_q   <= 1'b1;
        ph_q    <= '0;
        first_q <= 1'b0;
        last_q  <= ptr_last;
        if (!ptr_last) begin
          if (nib_q == np_q) begin
            nib_q <= '0;
            row_q <= row_q + 1'b1;
          end else begin
            nib_q <= nib_q + 1'b1;
          end
        end
      end else if (vld_q) begin
        sreg_q <= sh;
        ph_q   <= ph_q + 1'b1;
        if (finish) begin
          vld_q  <= 1'b0;
          busy_q <= 1'b0;
          ph_q   <= '0;
        end
      end
    end
  end

  AST_REQ_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) req |-> busy); // R2
  AST_NIB_RANGE:   assert property (@(posedge clk) disable iff (!rst_n) req |-> (req_nib <= np_q)); // R5
  AST_NO_GAP:      assert property (@(posedge clk) disable iff (!rst_n) out_vld |=> (out_vld || done)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && !out_vld)); // R8
  AST_BUSY_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (busy && start && !out_vld) |=> busy); // R9
endmodule

// File: tb/sc_ddr_serializer_tb_top.sv
module sc_ddr_serializer_tb_top;
  localparam int ROWS = 3;
  localparam int COLS = 8;
  localparam int SCW  = 4;
  localparam int NSC  = COLS / SCW;
  localparam int CYC  = SCW * 2;
  localparam int RW   = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] depth = 2'd0;
  logic [COLS*4-1:0] row_data;
  logic req, out_vld, busy, done;
  logic [RW-1:0] req_row;
  logic [1:0] req_nib;
  logic [NSC-1:0] out_r, out_f;
  int seed = 0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sc_ddr_serializer #(.ROWS(ROWS), .COLS(COLS), .SCW(SCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .depth(depth), .row_data(row_data),
    .req(req), .req_row(req_row), .req_nib(req_nib), .out_r(out_r), .out_f(out_f),
    .out_vld(out_vld), .busy(busy), .done(done));

  function automatic logic [3:0] pix(int r, int n, int c, int sd);
    return 4'((r * 7 + n * 5 + c * 3 + sd) & 15);
  endfunction

  always_comb begin
    for (int c = 0; c < COLS; c++) row_data[c*4 +: 4] = pix(int'(req_row), int'(req_nib), c, seed);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(input int dep, input int sd, input bit poke);
    int np, passes, total, vcnt, dones;
    bit ended;
    np = (dep == 0) ? 1 : (dep == 1) ? 2 : 3;
    passes = ROWS * np;
    total = passes * CYC;
    seed = sd;
    depth = 2'(dep);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; depth = 2'((dep + 1) % 4);
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    chk(req == 1'b1 && req_row == 0 && req_nib == 0, "R2 first request", int'(req), 1);
    chk(out_vld == 1'b0, "R2 no output on load cycle", int'(out_vld), 0);
    vcnt = 0; ended = 1'b0; dones = 0;
    for (int cyc = 0; cyc < total + 6; cyc++) begin
      @(negedge clk);
      start = (poke && (vcnt == 5 || vcnt == CYC + 1)) ? 1'b1 : 1'b0;
      if (done) dones++;
      if (out_vld) begin
        int p, t, r, n;
        p = vcnt / CYC; t = vcnt % CYC; r = p / np; n = p % np;
        chk(!ended, "R7 valid after gap", vcnt, total);
        chk(busy == 1'b1, "R8 busy during stream", int'(busy), 1);
        for (int s = 0; s < NSC; s++) begin
          logic [3:0] v;
          int c, b;
          c = s * SCW + (2 * t) / 4;
          b = (2 * t) % 4;
          v = pix(r, n, c, sd);
          chk(out_r[s] == v[3 - b], "R3 R4 R5 rising bit", int'(out_r[s]), int'(v[3 - b]));
          chk(out_f[s] == v[2 - b], "R3 R4 R5 falling bit", int'(out_f[s]), int'(v[2 - b]));
        end
        if (t == CYC - 1 && p < passes - 1) begin
          chk(req == 1'b1, "R2 request before empty", int'(req), 1);
          chk(int'(req_row) == (p + 1) / np && int'(req_nib) == (p + 1) % np, "R5 request order",
              int'(req_row) * 4 + int'(req_nib), ((p + 1) / np) * 4 + (p + 1) % np);
        end else begin
          chk(req == 1'b0, "R2 no stray request", int'(req), 0);
        end
        vcnt++;
      end else begin
        chk(out_r == '0 && out_f == '0, "R10 lines quiet", int'(out_r) + int'(out_f), 0);
        chk(req == 1'b0, "R2 no request when idle", int'(req), 0);
        if (vcnt > 0 && !ended) begin
          ended = 1'b1;
          chk(done == 1'b1, "R8 done after last bit", int'(done), 1);
          chk(busy == 1'b0, "R8 busy low at done", int'(busy), 0);
          chk(vcnt == total, "R6 R9 valid cycle count", vcnt, total);
        end
      end
    end
    start = 1'b0;
    chk(ended, "R7 stream ended", int'(ended), 1);
    chk(dones == 1, "R8 single done pulse", dones, 1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && req == 0 && out_vld == 0, "R1 reset outputs", int'(busy) + int'(done) + int'(req) + int'(out_vld), 0);
    chk(out_r == '0 && out_f == '0, "R1 reset lines", int'(out_r) + int'(out_f), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && out_vld == 0, "R1 idle after reset", int'(busy) + int'(out_vld), 0);
    run_frame(0, 1, 1'b0);
    run_frame(1, 4, 1'b0);
    run_frame(2, 9, 1'b1);
    run_frame(3, 2, 1'b0);
    run_frame(0, 11, 1'b1);
    run_frame(1, 6, 1'b1);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule